// File: doc/BRIEF.md
# Stopwatch with Split Hold

This block is a one-minute stopwatch core. A built-in prescaler divides the system clock down to a 10 ms step, and a four-digit BCD count advances on each step. The digits, from most to least significant, are tens of seconds, units of seconds, tenths and hundredths. The count runs from 00.00 up to 59.99 and then wraps back to 00.00. A decimal-point enable stays lit between the units-of-seconds digit and the tenths digit.

A level run switch controls counting. Raising it clears the time and starts counting from zero. Lowering it stops the count and leaves the stopped time on the outputs.

A freeze push-button toggles a display hold while the internal count keeps running. Each press that enters the hold also writes the time into a small ring of lap slots. A recall input with an index shows any stored lap on the digit outputs. The inputs are assumed to be synchronous and already free of bounce. Segment decoding and display multiplexing are done outside this block.

Top module: `lapwatch`

## Requirements
- R1: While run_sw is high, the time advances by exactly one hundredth every TICK_DIV clock cycles. The first step comes TICK_DIV cycles after the clock edge that sees run_sw rise. Between steps the time does not change.
- R2: Each digit output is BCD. sec_tens lies in 0..5 and the other three digits lie in 0..9. A count of n hundredths shows as sec_tens=n/1000, sec_ones=(n/100)%10, tenths=(n/10)%10 and hundredths=n%10.
- R3: A step from 59.99 gives 00.00.
- R4: dp_on is 1 at all times, including during and after reset.
- R5: On the clock edge where run_sw is sampled high after being sampled low, the time and the prescaler both clear to zero, so the outputs show 00.00.
- R6: While run_sw is low, the time holds its value, and the outputs keep showing the time that was present when the switch fell.
- R7: A rising edge of freeze_btn when the display is not held does two things. The outputs then hold the time present just before that edge, and the internal count keeps running. The next rising edge releases the hold, and the outputs show the live count again.
- R8: Each press that enters the hold writes the time into the next lap slot. Slots are written in order 0, 1, 2, 3 and then wrap, so the fifth capture overwrites slot 0. A press that releases the hold stores nothing.
- R9: While recall_en is high, the outputs show lap slot recall_idx. This takes priority over both the hold and the live count. Recall has no effect on the count.
- R10: Synchronous reset clears the time, the lap slots, the hold state and the lap write position. After reset the outputs show 00.00 and every lap slot reads 00.00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_sw | input | 1 | Run level: rising clears and starts, low stops |
| freeze_btn | input | 1 | Freeze button; each rising edge toggles display hold |
| recall_en | input | 1 | Show a stored lap instead of the live or held time |
| recall_idx | input | $clog2(LAP_DEPTH) | Lap slot to show |
| sec_tens | output | 4 | Tens of seconds, BCD |
| sec_ones | output | 4 | Units of seconds, BCD |
| tenths | output | 4 | Tenths of a second, BCD |
| hundredths | output | 4 | Hundredths of a second, BCD |
| dp_on | output | 1 | Decimal-point enable between seconds and tenths |

## Verification
The assertions check several properties on every cycle:
- the shown digits are always legal BCD;
- the live count moves only on a prescaler step or a start clear;
- the count wraps to zero after 59.99;
- a start leaves the count at zero;
- a low run switch freezes the count;
- the held display stays steady while no recall is active.

Some behaviour only the bench scenarios can show. One such behaviour is the exact cycle spacing of steps across a full minute sweep, with its wrap. Others are the value captured at a freeze press, the release back to the live count, the order and overwrite of lap slots, and recall priority over a held display.

// File: rtl/lapwatch.sv
module lapwatch #(
  parameter int TICK_DIV  = 500000,
  parameter int LAP_DEPTH = 4,
  localparam int PW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2),
  localparam int LW = $clog2(LAP_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_sw,
  input  logic          freeze_btn,
  input  logic          recall_en,
  input  logic [LW-1:0] recall_idx,
  output logic [3:0]    sec_tens,
  output logic [3:0]    sec_ones,
  output logic [3:0]    tenths,
  output logic [3:0]    hundredths,
  output logic          dp_on
);

  logic [PW-1:0] pre;
  logic          run_q, frz_q, frozen;
  logic [LW-1:0] wr_ptr;
  logic [15:0]   live, hold, nxt, disp;
  logic [15:0]   lap [LAP_DEPTH];

  wire start = run_sw & ~run_q;
  wire tick  = run_sw & ~start & (pre == PW'(TICK_DIV - 1));
  wire press = freeze_btn & ~frz_q;

  always_comb begin
    nxt = live;
    if (live[3:0] != 4'd9) nxt[3:0] = live[3:0] + 4'd1;
    else begin
      nxt[3:0] = 4'd0;
      if (live[7:4] != 4'd9) nxt[7:4] = live[7:4] + 4'd1;
      else begin
        nxt[7:4] = 4'd0;
        if (live[11:8] != 4'd9) nxt[11:8] = live[11:8] + 4'd1;
        else begin
          nxt[11:8] = 4'd0;
          if (live[15:12] != 4'd5) nxt[15:12] = live[15:12] + 4'd1;
          else nxt[15:12] = 4'd0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      run_q  <= 1'b0;
      frz_q  <= 1'b0;
      frozen <= 1'b0;
      wr_ptr <= '0;
      live   <= '0;
      hold   <= '0;
      for (int i = 0; i < LAP_DEPTH; i++) lap[i] <= '0;
    end else begin
      run_q <= run_sw;
      frz_q <= freeze_btn;
      if (start) begin
        pre  <= '0;
        live <= '0;
      end else if (run_sw) begin
        if (tick) begin
          pre  <= '0;
          live <= nxt;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      if (press) begin
        if (frozen) begin
          frozen <= 1'b0;
        end else begin
          frozen      <= 1'b1;
          hold        <= live;
          lap[wr_ptr] <= live;
          wr_ptr      <= (wr_ptr == LW'(LAP_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
      end
    end
  end

  assign disp  = recall_en ? lap[recall_idx] : (frozen ? hold : live);
  assign {sec_tens, sec_ones, tenths, hundredths} = disp;
  assign dp_on = 1'b1;

endmodule

module lapwatch_chk (
  input logic        clk,
  input logic        rst,
  input logic        run_sw,
  input logic        recall_en,
  input logic        tick,
  input logic        start,
  input logic        frozen,
  input logic [15:0] live,
  input logic [15:0] disp
);

  p_bcd_range_r2: assert property (@(posedge clk) disable iff (rst)
    disp[15:12] <= 4'd5 && disp[11:8] <= 4'd9 && disp[7:4] <= 4'd9 && disp[3:0] <= 4'd9);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(live));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && live == 16'h5999) |=> live == 16'h0000);

  p_start_clear_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> live == 16'h0000);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run_sw |=> $stable(live));

  p_freeze_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (frozen && $past(frozen) && !recall_en && $past(!recall_en)) |-> $stable(disp));

endmodule

bind lapwatch lapwatch_chk u_chk (
  .clk(clk), .rst(rst), .run_sw(run_sw), .recall_en(recall_en),
  .tick(tick), .start(start), .frozen(frozen), .live(live), .disp(disp)
);

// File: tb/lapwatch_tb_top.sv
module lapwatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst, run_sw, freeze_btn, recall_en;
  logic [1:0] recall_idx;
  logic [3:0] sec_tens, sec_ones, tenths, hundredths;
  logic dp_on;
  logic [15:0] disp;
  int n_chk = 0, n_fail = 0, m = 0;
  logic [15:0] lap_exp [4];
  logic [15:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  lapwatch #(.TICK_DIV(DIV), .LAP_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .run_sw(run_sw), .freeze_btn(freeze_btn),
    .recall_en(recall_en), .recall_idx(recall_idx),
    .sec_tens(sec_tens), .sec_ones(sec_ones), .tenths(tenths),
    .hundredths(hundredths), .dp_on(dp_on)
  );

  assign disp = {sec_tens, sec_ones, tenths, hundredths};

  function automatic logic [15:0] bcd(int n);
    int v = n % 6000;
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      m++;
      @(negedge clk);
    end
  endtask

  task automatic press();
    freeze_btn = 1'b1;
    step();
    freeze_btn = 1'b0;
    step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; run_sw = 1'b0; freeze_btn = 1'b0; recall_en = 1'b0; recall_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 dp during reset", {15'd0, dp_on}, 16'd1);
    rst = 1'b0;
    step();
    chk("R10 reset time", disp, 16'h0000);
    chk("R4 dp after reset", {15'd0, dp_on}, 16'd1);
    for (int i = 0; i < 4; i++) begin
      recall_en = 1'b1; recall_idx = 2'(i);
      #1 chk("R10 reset lap", disp, 16'h0000);
    end
    recall_en = 1'b0;
    step(10);
    chk("R6 idle before run", disp, 16'h0000);

    run_sw = 1'b1;
    @(posedge clk); m = 0; @(negedge clk);
    chk("R5 start clear", disp, 16'h0000);
    for (int k = 0; k < 6002 * DIV; k++) begin
      step();
      if ((m / DIV) % 6000 == 0 && m >= DIV) chk("R3 wrap", disp, bcd(m / DIV));
      else chk("R1 R2 step", disp, bcd(m / DIV));
    end

    snap = disp;
    freeze_btn = 1'b1; step(); freeze_btn = 1'b0;
    chk("R7 freeze captures", disp, snap);
    step(10 * DIV + 1);
    chk("R7 freeze holds", disp, snap);
    freeze_btn = 1'b1; step(); freeze_btn = 1'b0;
    chk("R7 release to live", disp, bcd(m / DIV));
    lap_exp[0] = snap;

    for (int k = 1; k < 5; k++) begin
      step(k * DIV + 1);
      lap_exp[k % 4] = disp;
      press();
      step(k);
      press();
    end
    for (int i = 0; i < 4; i++) begin
      recall_en = 1'b1; recall_idx = 2'(i);
      #1 chk("R8 lap order and overwrite", disp, lap_exp[i]);
    end
    step(5 * DIV);
    recall_en = 1'b0;
    #1 chk("R9 recall leaves count running", disp, bcd(m / DIV));

    snap = disp;
    freeze_btn = 1'b1; step(); freeze_btn = 1'b0;
    step(2);
    recall_en = 1'b1; recall_idx = 2'd0;
    #1 chk("R9 recall over hold", disp, lap_exp[0]);
    recall_idx = 2'd1;
    #1 chk("R8 capture in slot 1", disp, snap);
    recall_en = 1'b0;
    #1 chk("R7 hold after recall", disp, snap);
    press();
    chk("R7 second release", disp, bcd(m / DIV));

    snap = disp;
    run_sw = 1'b0;
    step(20 * DIV);
    chk("R6 stopped time held", disp, snap);

    run_sw = 1'b1;
    @(posedge clk); m = 0; @(negedge clk);
    chk("R5 restart clear", disp, 16'h0000);
    step(DIV - 1);
    chk("R1 no step before period", disp, 16'h0000);
    step();
    chk("R1 first step at period", disp, 16'h0001);

    summary();
    $finish;
  end
endmodule